// File: doc/BRIEF.md
# Link Idle Substate Power Sequencer

This block sits next to the link power-management logic of a serial link controller. Once the link has settled into its L1 idle state, a one-cycle entry request hands control to this sequencer. It picks how deep to go: plain L1, the shallow substate L1.1 or the deep substate L1.2. It then switches off the PHY power resources one at a time, waiting a programmable settle interval after each step. Three resources are controlled: the receiver/transmitter logic, the PLL and the common-mode voltage keeper.

Wake-up comes from an active-low sideband request pin rather than from the data lanes, so the receive and transmit paths can be switched off completely. On wake, the resources come back in the reverse order, again with a settle interval after each step. A one-cycle done pulse marks the return to full power. The time from the wake to that point is measured in clock cycles and compared with a per-depth budget; a sticky flag records any resume that runs over. Whatever the depth, the status output shows only "L1", so software never sees the substates.

Top module: `lpss_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all three enables are 1, `link_sts` is 2'b00, and `resume_done` and `lat_viol` are 0.
- R2: The depth is chosen at the cycle `enter_req` is sampled in L0. It is L1.2 if `cfg_sub2_en` and `cfg_sub2_ok` are both 1, otherwise L1.1 if `cfg_sub1_en` is 1, otherwise plain L1. When power-down completes, the enables {cm, pll, txrx} read 3'b110 for plain L1, 3'b100 for L1.1 and 3'b000 for L1.2.
- R3: Power-down switches off txrx at the edge that samples `enter_req`, then pll, then cm (L1.2 only). Each step comes cfg_settle+1 cycles after the previous one. No two enables change in the same cycle.
- R4: On a wake, the most recently removed resource is restored at the edge that samples `wake_n` low. The others follow in reverse order, each cfg_settle+1 cycles after the previous one.
- R5: `link_sts` is 2'b00 only in full-power L0 and 2'b01 at every other time, whatever the depth. It takes no other value.
- R6: A low `wake_n` sampled during power-down aborts it. Restoration starts at once from whatever depth has been reached.
- R7: `resume_done` is high for exactly one cycle, in the first cycle back in L0 after a wake-started resume.
- R8: The resume time is counted from the edge that samples the wake. If it exceeds the budget for the deepest level reached (BUD_L1, BUD_SUB1 or BUD_SUB2 cycles), `lat_viol` rises and stays high until reset.
- R9: `enter_req` has no effect outside L0, and `wake_n` has no effect in L0 or while resuming.
- R10: Changes to the depth-enable inputs after entry do not change the depth being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Request to start idle power-down (sampled in L0) |
| cfg_sub1_en | input | 1 | Allow shallow substate L1.1 |
| cfg_sub2_en | input | 1 | Allow deep substate L1.2 |
| cfg_sub2_ok | input | 1 | Latency tolerance permits L1.2 |
| cfg_settle | input | SETTLE_W | Settle cycles minus one after each power step |
| wake_n | input | 1 | Active-low sideband wake request |
| phy_txrx_en | output | 1 | Receiver/transmitter logic enable |
| phy_pll_en | output | 1 | PLL enable |
| phy_cm_en | output | 1 | Common-mode keeper enable |
| link_sts | output | 2 | Software-visible link state: 00 L0, 01 L1 |
| resume_done | output | 1 | One-cycle pulse on return to L0 |
| lat_viol | output | 1 | Sticky resume-budget violation |

## Verification
The bench builds the block with budgets of 12, 40 and 90 cycles for plain L1, L1.1 and L1.2 in place of the multi-thousand-cycle defaults. It keeps the 8-bit settle field. With a settle value of 3, every depth resumes well inside its budget. Raising the settle value to 30 pushes the L1.2 resume to 93 cycles, so the violation flag can be reached in a short run. The bench also compares a behavioural model cycle by cycle through abort, ignored-input and reconfiguration scenarios.

// File: rtl/lpss_pkg.sv
package lpss_pkg;

  // Number of PHY resources switched by the sequencer: txrx, pll, cm.
  localparam int NRES = 3;

  typedef enum logic [1:0] {
    PH_ON   = 2'd0,
    PH_DOWN = 2'd1,
    PH_REST = 2'd2,
    PH_UP   = 2'd3
  } phase_e;

  // Count of resources currently removed; also the idle depth.
  typedef logic [1:0] depth_t;

  localparam depth_t D_PLAIN = 2'd1;
  localparam depth_t D_SUB1  = 2'd2;
  localparam depth_t D_SUB2  = 2'd3;

  localparam logic [1:0] STS_L0 = 2'b00;
  localparam logic [1:0] STS_L1 = 2'b01;

  // Depth chosen at entry from the enable configuration.
  function automatic depth_t pick_depth(input logic sub1_en, input logic sub2_en,
                                        input logic sub2_ok);
    if (sub2_en && sub2_ok) return D_SUB2;
    if (sub1_en) return D_SUB1;
    return D_PLAIN;
  endfunction

  // True when the elapsed resume count is beyond the budget of the depth.
  function automatic logic over_budget(input int unsigned elapsed, input depth_t d,
                                       input int unsigned b_plain, input int unsigned b_sub1,
                                       input int unsigned b_sub2);
    int unsigned lim;
    case (d)
      D_SUB2:  lim = b_sub2;
      D_SUB1:  lim = b_sub1;
      default: lim = b_plain;
    endcase
    return elapsed > lim;
  endfunction

endpackage

// File: rtl/lpss_step_timer.sv
module lpss_step_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic [SETTLE_W-1:0] settle,
  output logic                step_due
);

  logic [SETTLE_W-1:0] cnt;

  assign step_due = (cnt >= settle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (!step_due) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/lpss_resume_mon.sv
module lpss_resume_mon
  import lpss_pkg::*;
#(
  parameter int LAT_W    = 16,
  parameter int BUD_L1   = 1000,
  parameter int BUD_SUB1 = 5000,
  parameter int BUD_SUB2 = 25000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  depth_t depth_at_wake,
  input  logic   running,
  output logic   viol
);

  logic [LAT_W-1:0] lat;
  depth_t           dep;
  int unsigned      elapsed;
  logic             late_now;

  assign elapsed  = 32'(lat) + 32'd1;
  assign late_now = running && over_budget(elapsed, dep, BUD_L1, BUD_SUB1, BUD_SUB2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat  <= '0;
      dep  <= D_PLAIN;
      viol <= 1'b0;
    end else begin
      if (start) begin
        lat <= '0;
        dep <= depth_at_wake;
      end else if (running && (lat != '1)) begin
        lat <= lat + 1'b1;
      end
      if (late_now) viol <= 1'b1;
    end
  end

  // R8
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);

  // R8
  viol_only_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol && !running) |=> !viol);

endmodule

// File: rtl/lpss_rail_map.sv
module lpss_rail_map
  import lpss_pkg::*;
(
  input  depth_t          off_lvl,
  output logic [NRES-1:0] rail_en
);

  // Resource i stays powered while fewer than i+1 resources are removed.
  for (genvar i = 0; i < NRES; i++) begin : g_rail
    assign rail_en[i] = (off_lvl <= depth_t'(i));
  end

endmodule

// File: rtl/lpss_ctrl.sv
module lpss_ctrl
  import lpss_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int LAT_W    = 16,
  parameter int BUD_L1   = 1000,
  parameter int BUD_SUB1 = 5000,
  parameter int BUD_SUB2 = 25000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enter_req,
  input  logic                cfg_sub1_en,
  input  logic                cfg_sub2_en,
  input  logic                cfg_sub2_ok,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                wake_n,
  output logic                phy_txrx_en,
  output logic                phy_pll_en,
  output logic                phy_cm_en,
  output logic [1:0]          link_sts,
  output logic                resume_done,
  output logic                lat_viol
);

  phase_e          ph;
  depth_t          lvl;
  depth_t          goal;
  logic            step_due;
  logic [NRES-1:0] rails;

  // Named sequencing events.
  logic go_down, wake_hit, adv_down, settle_end, adv_up, up_end, tmr_restart;

  assign go_down     = (ph == PH_ON) && enter_req;
  assign wake_hit    = ((ph == PH_DOWN) || (ph == PH_REST)) && !wake_n;
  assign adv_down    = (ph == PH_DOWN) && wake_n && step_due && (lvl != goal);
  assign settle_end  = (ph == PH_DOWN) && wake_n && step_due && (lvl == goal);
  assign adv_up      = (ph == PH_UP) && step_due && (lvl != '0);
  assign up_end      = (ph == PH_UP) && step_due && (lvl == '0);
  assign tmr_restart = go_down || wake_hit || adv_down || adv_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_ON;
      lvl         <= '0;
      goal        <= D_PLAIN;
      resume_done <= 1'b0;
    end else begin
      resume_done <= up_end;
      if (go_down) begin
        goal <= pick_depth(cfg_sub1_en, cfg_sub2_en, cfg_sub2_ok);
        lvl  <= D_PLAIN;
        ph   <= PH_DOWN;
      end else if (wake_hit) begin
        lvl <= lvl - 1'b1;
        ph  <= PH_UP;
      end else if (adv_down) begin
        lvl <= lvl + 1'b1;
      end else if (settle_end) begin
        ph <= PH_REST;
      end else if (adv_up) begin
        lvl <= lvl - 1'b1;
      end else if (up_end) begin
        ph <= PH_ON;
      end
    end
  end

  lpss_step_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (tmr_restart),
    .settle   (cfg_settle),
    .step_due (step_due)
  );

  lpss_resume_mon #(
    .LAT_W   (LAT_W),
    .BUD_L1  (BUD_L1),
    .BUD_SUB1(BUD_SUB1),
    .BUD_SUB2(BUD_SUB2)
  ) u_mon (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (wake_hit),
    .depth_at_wake (lvl),
    .running       (ph == PH_UP),
    .viol          (lat_viol)
  );

  lpss_rail_map u_rails (
    .off_lvl (lvl),
    .rail_en (rails)
  );

  assign phy_txrx_en = rails[0];
  assign phy_pll_en  = rails[1];
  assign phy_cm_en   = rails[2];
  assign link_sts    = (ph == PH_ON) ? STS_L0 : STS_L1;

  // R3
  one_rail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rails ^ $past(rails)) <= 1);

  // R5
  sts_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&rails) |-> (link_sts == STS_L1));

  // R5
  sts_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_sts == STS_L0) || (link_sts == STS_L1));

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DOWN && !wake_n) |=> (ph == PH_UP));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |-> ((link_sts == STS_L0) && (&rails)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_done |=> !resume_done);

  // R9
  rest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_REST && wake_n) |=> $stable(rails));

  // R9
  on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ON && !enter_req) |=> (&rails));

endmodule

// File: tb/lpss_ctrl_tb_top.sv
module lpss_ctrl_tb_top;

  localparam int SW = 8;
  localparam int B1 = 12;
  localparam int BS1 = 40;
  localparam int BS2 = 90;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enter_req = 1'b0;
  logic          cfg_sub1_en = 1'b0;
  logic          cfg_sub2_en = 1'b0;
  logic          cfg_sub2_ok = 1'b0;
  logic [SW-1:0] cfg_settle = 8'd3;
  logic          wake_n = 1'b1;
  logic          phy_txrx_en, phy_pll_en, phy_cm_en;
  logic [1:0]    link_sts;
  logic          resume_done, lat_viol;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lpss_ctrl #(
    .SETTLE_W(SW), .LAT_W(16), .BUD_L1(B1), .BUD_SUB1(BS1), .BUD_SUB2(BS2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req),
    .cfg_sub1_en(cfg_sub1_en), .cfg_sub2_en(cfg_sub2_en), .cfg_sub2_ok(cfg_sub2_ok),
    .cfg_settle(cfg_settle), .wake_n(wake_n),
    .phy_txrx_en(phy_txrx_en), .phy_pll_en(phy_pll_en), .phy_cm_en(phy_cm_en),
    .link_sts(link_sts), .resume_done(resume_done), .lat_viol(lat_viol)
  );

  // Behavioural reference: mode 0 full power, 1 shedding, 2 holding, 3 restoring.
  int m_mode = 0;
  int m_off = 0;
  int m_goal = 1;
  int m_el = 0;
  int m_since = 0;
  int m_bud = 0;
  bit m_viol = 0;
  bit m_done = 0;

  function automatic int budget_of(input int removed);
    if (removed >= 3) return BS2;
    if (removed == 2) return BS1;
    return B1;
  endfunction

  function automatic int goal_of(input bit s1, input bit s2, input bit ok);
    int g;
    g = 1;
    if (s1) g = 2;
    if (s2 && ok) g = 3;
    return g;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_off = 0; m_goal = 1; m_el = 0;
      m_since = 0; m_bud = 0; m_viol = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_mode == 0) begin
        if (enter_req) begin
          m_goal = goal_of(cfg_sub1_en, cfg_sub2_en, cfg_sub2_ok);
          m_off = 1; m_el = 0; m_mode = 1;
        end
      end else if ((m_mode == 1 || m_mode == 2) && !wake_n) begin
        m_bud = budget_of(m_off);
        m_off = m_off - 1; m_el = 0; m_since = 0; m_mode = 3;
      end else if (m_mode == 1) begin
        m_el++;
        if (m_el == int'(cfg_settle) + 1) begin
          m_el = 0;
          if (m_off == m_goal) m_mode = 2;
          else m_off++;
        end
      end else if (m_mode == 3) begin
        m_since++;
        if (m_since > m_bud) m_viol = 1;
        m_el++;
        if (m_el == int'(cfg_settle) + 1) begin
          m_el = 0;
          if (m_off == 0) begin
            m_mode = 0; m_done = 1;
          end else m_off--;
        end
      end
    end
  end

  function automatic logic [2:0] rails_exp(input int off);
    logic [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = (off <= k);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      logic [2:0] r;
      r = {phy_cm_en, phy_pll_en, phy_txrx_en};
      chk(r == rails_exp(m_off), "R3/R4 rails", int'(r), int'(rails_exp(m_off)));
      chk(link_sts == ((m_mode == 0) ? 2'b00 : 2'b01), "R5 link_sts",
          int'(link_sts), (m_mode == 0) ? 0 : 1);
      chk(resume_done == m_done, "R7 resume_done", int'(resume_done), int'(m_done));
      chk(lat_viol == m_viol, "R8 lat_viol", int'(lat_viol), int'(m_viol));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_enter();
    enter_req = 1'b1; step(1); enter_req = 1'b0;
  endtask

  task automatic pulse_wake(input int n);
    wake_n = 1'b0; step(n); wake_n = 1'b1;
  endtask

  function automatic int rails_now();
    return int'({phy_cm_en, phy_pll_en, phy_cm_en & 1'b0 | phy_txrx_en});
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
  end

  initial begin
    step(3);
    // R1: reset values while held
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b111, "R1 rails in reset", rails_now(), 7);
    chk(link_sts == 2'b00 && !resume_done && !lat_viol, "R1 status in reset",
        int'(link_sts), 0);
    rst_n = 1'b1;
    step(2);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b111, "R1 rails after reset", rails_now(), 7);

    // R2: deep substate, settle 3
    cfg_settle = 8'd3; cfg_sub1_en = 1; cfg_sub2_en = 1; cfg_sub2_ok = 1;
    pulse_enter();
    chk(phy_txrx_en == 1'b0 && phy_pll_en, "R3 txrx drops first", rails_now(), 6);
    step(20);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b000, "R2 L1.2 rest", rails_now(), 0);
    chk(link_sts == 2'b01, "R5 deep reads L1", int'(link_sts), 1);
    pulse_wake(1);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b100, "R4 cm restored first", rails_now(), 4);
    step(20);

    // R2/R10: shallow substate, then change enables and poke entry while held
    cfg_sub2_ok = 0;
    pulse_enter();
    step(20);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b100, "R2 L1.1 rest", rails_now(), 4);
    cfg_sub2_ok = 1;
    step(10);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b100, "R10 depth held", rails_now(), 4);
    pulse_enter();
    step(5);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b100, "R9 entry ignored in rest", rails_now(), 4);
    pulse_wake(3);
    step(20);

    // R2: plain L1, and wake ignored in L0
    cfg_sub1_en = 0; cfg_sub2_en = 0;
    pulse_wake(4);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b111 && link_sts == 2'b00,
        "R9 wake ignored in L0", rails_now(), 7);
    pulse_enter();
    step(12);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b110, "R2 plain L1 rest", rails_now(), 6);
    pulse_wake(1);
    step(10);
    chk(link_sts == 2'b00, "R4 plain L1 resumed", int'(link_sts), 0);

    // R6: abort while shedding toward L1.2, settle 5
    cfg_settle = 8'd5; cfg_sub1_en = 1; cfg_sub2_en = 1; cfg_sub2_ok = 1;
    pulse_enter();
    step(7);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b100, "R3 pll off second", rails_now(), 4);
    wake_n = 1'b0; step(1); wake_n = 1'b1;
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b110, "R6 abort restores pll", rails_now(), 6);
    step(20);
    chk(lat_viol == 1'b0, "R8 no violation within budgets", int'(lat_viol), 0);

    // R8: long settle makes the L1.2 resume exceed its budget
    cfg_settle = 8'd30;
    pulse_enter();
    step(100);
    chk({phy_cm_en, phy_pll_en, phy_txrx_en} == 3'b000, "R2 L1.2 rest long settle", rails_now(), 0);
    pulse_wake(1);
    step(110);
    chk(lat_viol == 1'b1, "R8 violation flagged", int'(lat_viol), 1);
    cfg_settle = 8'd3; cfg_sub2_en = 0; cfg_sub1_en = 0;
    pulse_enter();
    step(6);
    pulse_wake(1);
    step(10);
    chk(lat_viol == 1'b1, "R8 flag sticky", int'(lat_viol), 1);
    finish_run();
  end

endmodule